// File: doc/BRIEF.md
# Vector Byte Permute Unit

The unit assembles a 128-bit result one byte at a time. Every output byte is taken from a 32-byte pool formed from two 128-bit sources: source A supplies pool entries 0 to 15 and source T supplies entries 16 to 31. Source T holds the previous contents of the destination register, so the issuing core reads it as an operand and then overwrites it with the result. A third 128-bit vector, B, holds one control byte for each output lane. The low five bits of that byte choose the pool entry for the lane.

A 5-bit sub-opcode selects the mode. In left-indexed mode the control value is used as it is. In right-indexed mode every index is mirrored to 31 minus itself before the byte is selected. An operation is accepted in any cycle where the valid input is high, and its result is registered one clock later. Operations may be issued on every cycle. A sub-opcode that matches neither mode produces no result. Instead it raises a one-cycle illegal flag at the time the result would have been due.

Top module: `vbyte_permute`

## Requirements
- R1: Bytes are numbered big-endian in every vector. Byte 0 is bits [127:120] and byte 15 is bits [7:0]. Output byte i is driven by control byte i of B.
- R2: An effective index from 0 to 15 selects byte number index of source A.
- R3: An effective index from 16 to 31 selects byte number index minus 16 of source T.
- R4: Bits [7:5] of each control byte have no effect on the result.
- R5: When the sub-opcode is 5'h07 (right-indexed), each effective index is 31 minus the low five control bits. When it is 5'h03 (left-indexed), the effective index equals those bits.
- R6: Each lane is selected independently, so different lanes in one operation may take bytes from A and from T in any mix.
- R7: res_valid is high exactly one clock after a cycle with in_valid high and a legal sub-opcode. A new operation may be issued every cycle.
- R8: While rst_n is low, res_valid, res_illegal and res_data are all zero.
- R9: A valid input carrying any sub-opcode other than 5'h03 or 5'h07 raises res_illegal for one cycle, one clock later. For that operation res_valid stays low and res_data keeps its previous value.
- R10: In a cycle with in_valid low, res_valid and res_illegal go low on the next clock and res_data is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously outside the block |
| in_valid | input | 1 | Operation request in this cycle |
| op_sub | input | 5 | Sub-opcode selecting the mode (5'h03 left, 5'h07 right) |
| src_a | input | 128 | Source A, pool entries 0 to 15 |
| src_t | input | 128 | Source T (prior destination value), pool entries 16 to 31 |
| ctrl_b | input | 128 | One control byte per output lane |
| res_valid | output | 1 | Result valid, one clock after a legal request |
| res_illegal | output | 1 | One-cycle flag for an unrecognised sub-opcode |
| res_data | output | 128 | Registered permuted result |

## Verification
Every result and every illegal flag is due on the first rising edge after the request is sampled. The bench therefore drives each request on a falling edge and reads the outputs on the next falling edge, which is half a period after that one register stage has updated. In the back-to-back stream, a new request is driven on the same falling edge where the previous one is checked, so every cycle carries one check. The hold checks after illegal or idle cycles read res_data one edge later to confirm that it did not move.

// File: rtl/vperm_pkg.sv
package vperm_pkg;
  localparam int unsigned VEC_W_DEF    = 128;
  localparam int unsigned BYTE_W_DEF   = 8;
  localparam int unsigned OP_W_DEF     = 5;
  localparam logic [4:0]  OP_LEFT_DEF  = 5'h03;
  localparam logic [4:0]  OP_RIGHT_DEF = 5'h07;

  typedef enum logic [1:0] {
    MODE_LEFT  = 2'd0,
    MODE_RIGHT = 2'd1,
    MODE_BAD   = 2'd2
  } perm_mode_e;
endpackage

// File: rtl/vperm_decode.sv
module vperm_decode
  import vperm_pkg::*;
#(
  parameter int unsigned  OP_W     = OP_W_DEF,
  parameter logic [OP_W-1:0] OP_LEFT  = OP_LEFT_DEF,
  parameter logic [OP_W-1:0] OP_RIGHT = OP_RIGHT_DEF
) (
  input  logic [OP_W-1:0] op_sub,
  output perm_mode_e      mode,
  output logic            legal,
  output logic            mirror
);
  always_comb begin
    if (op_sub == OP_LEFT)       mode = MODE_LEFT;
    else if (op_sub == OP_RIGHT) mode = MODE_RIGHT;
    else                         mode = MODE_BAD;
    legal  = (mode != MODE_BAD);
    mirror = (mode == MODE_RIGHT);
  end
endmodule

// File: rtl/vperm_lane.sv
module vperm_lane #(
  parameter int unsigned VEC_W  = 128,
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned LANES = VEC_W / BYTE_W,
  localparam int unsigned IDX_W = $clog2(2 * LANES)
) (
  input  logic [VEC_W-1:0]  src_a,
  input  logic [VEC_W-1:0]  src_t,
  input  logic [BYTE_W-1:0] ctrl,
  input  logic              mirror,
  output logic [BYTE_W-1:0] lane_out
);
  logic [IDX_W-1:0] raw_idx;
  logic [IDX_W-1:0] eff_idx;
  logic [VEC_W-1:0] half;
  int unsigned      top_bit;

  always_comb begin
    raw_idx  = ctrl[IDX_W-1:0];
    // mirroring within a power-of-two pool is a bitwise inversion
    eff_idx  = mirror ? ~raw_idx : raw_idx;
    half     = eff_idx[IDX_W-1] ? src_t : src_a;
    top_bit  = VEC_W - 1 - BYTE_W * int'(eff_idx[IDX_W-2:0]);
    lane_out = half[top_bit -: BYTE_W];
  end
endmodule

// File: rtl/vperm_outreg.sv
module vperm_outreg #(
  parameter int unsigned VEC_W = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic             bad,
  input  logic [VEC_W-1:0] data_in,
  output logic             q_valid,
  output logic             q_illegal,
  output logic [VEC_W-1:0] q_data
);
  logic             valid_nx;
  logic             illegal_nx;
  logic [VEC_W-1:0] data_nx;

  always_comb begin
    valid_nx   = take;
    illegal_nx = bad;
    data_nx    = take ? data_in : q_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_valid   <= 1'b0;
      q_illegal <= 1'b0;
    end else begin
      q_valid   <= valid_nx;
      q_illegal <= illegal_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q_data <= '0;
    else if (take) q_data <= data_nx;
  end

  // R10
  hold_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(q_data));

  // R9
  excl_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(q_valid && q_illegal));
endmodule

// File: rtl/vbyte_permute.sv
module vbyte_permute
  import vperm_pkg::*;
#(
  parameter int unsigned VEC_W  = VEC_W_DEF,
  parameter int unsigned BYTE_W = BYTE_W_DEF,
  parameter int unsigned OP_W   = OP_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [OP_W-1:0]  op_sub,
  input  logic [VEC_W-1:0] src_a,
  input  logic [VEC_W-1:0] src_t,
  input  logic [VEC_W-1:0] ctrl_b,
  output logic             res_valid,
  output logic             res_illegal,
  output logic [VEC_W-1:0] res_data
);
  localparam int unsigned LANES = VEC_W / BYTE_W;

  perm_mode_e       mode;
  logic             legal;
  logic             mirror;
  logic [VEC_W-1:0] perm_now;

  vperm_decode #(.OP_W(OP_W)) u_decode (
    .op_sub (op_sub),
    .mode   (mode),
    .legal  (legal),
    .mirror (mirror)
  );

  for (genvar gi = 0; gi < LANES; gi++) begin : g_lane
    localparam int unsigned HI = VEC_W - 1 - BYTE_W * gi;
    vperm_lane #(.VEC_W(VEC_W), .BYTE_W(BYTE_W)) u_lane (
      .src_a    (src_a),
      .src_t    (src_t),
      .ctrl     (ctrl_b[HI -: BYTE_W]),
      .mirror   (mirror),
      .lane_out (perm_now[HI -: BYTE_W])
    );
  end

  vperm_outreg #(.VEC_W(VEC_W)) u_outreg (
    .clk       (clk),
    .rst_n     (rst_n),
    .take      (in_valid && legal),
    .bad       (in_valid && !legal),
    .data_in   (perm_now),
    .q_valid   (res_valid),
    .q_illegal (res_illegal),
    .q_data    (res_data)
  );

  // R7
  valid_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(in_valid));

  // R9
  bad_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_illegal |-> ($past(in_valid) && ($past(mode) == MODE_BAD)));

  // R10
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!res_valid && !res_illegal));
endmodule

// File: tb/vbyte_permute_bench.sv
module vbyte_permute_bench;
  localparam int PERIOD = 10;
  localparam logic [127:0] ID_V   = 128'h000102030405060708090A0B0C0D0E0F;
  localparam logic [127:0] HI_V   = 128'h101112131415161718191A1B1C1D1E1F;
  localparam logic [127:0] RHI_V  = 128'h1F1E1D1C1B1A19181716151413121110;
  localparam logic [127:0] RLO_V  = 128'h0F0E0D0C0B0A09080706050403020100;
  localparam logic [127:0] MIX_B  = 128'hE0F1A2B3C4D5E6F708192A3B4C5D6E7F;
  localparam logic [127:0] MIX_E  = 128'h001102130415061708190A1B0C1D0E1F;
  localparam int NV = 8;
  // sources fixed: A = ID_V, T = HI_V, so each pool byte equals its index
  localparam logic [4:0]   TB_OP [NV] = '{5'h03, 5'h03, 5'h03, 5'h03,
                                          5'h07, 5'h07, 5'h07, 5'h03};
  localparam logic [127:0] TB_B  [NV] = '{ID_V, HI_V, RHI_V, MIX_B,
                                          ID_V, HI_V, {128{1'b1}}, {128{1'b1}}};
  localparam logic [127:0] TB_E  [NV] = '{ID_V, HI_V, RHI_V, MIX_E,
                                          RHI_V, RLO_V, 128'h0, {16{8'h1F}}};
  localparam string TB_TAG [NV] = '{"R1 R2", "R3", "R6", "R4 R6",
                                    "R5", "R5", "R5 R4", "R4 R3"};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [4:0] op_sub = '0;
  logic [127:0] src_a = '0, src_t = '0, ctrl_b = '0;
  logic res_valid, res_illegal;
  logic [127:0] res_data;
  int n_chk = 0, n_bad = 0;

  always #(PERIOD/2) clk = ~clk;

  vbyte_permute u_vbyte_permute (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sub(op_sub),
    .src_a(src_a), .src_t(src_t), .ctrl_b(ctrl_b),
    .res_valid(res_valid), .res_illegal(res_illegal), .res_data(res_data)
  );

  function automatic logic [127:0] model(input logic [4:0] op,
      input logic [127:0] a, input logic [127:0] t, input logic [127:0] b);
    logic [255:0] pool;
    logic [127:0] r;
    pool = {a, t};
    for (int i = 0; i < 16; i++) begin
      int idx;
      idx = int'(b[127-8*i -: 5] & 5'h1F);
      idx = int'(b[127-8*i-3 -: 5]);
      if (op == 5'h07) idx = 31 - idx;
      r[127-8*i -: 8] = pool[255-8*idx -: 8];
    end
    return r;
  endfunction

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic [4:0] op, input logic [127:0] a,
                       input logic [127:0] t, input logic [127:0] b);
    in_valid = v; op_sub = op; src_a = a; src_t = t; ctrl_b = b;
  endtask

  initial begin
    #(PERIOD*150000);
    n_bad++; n_chk++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [127:0] held, pa, pt, pb, pe;
    logic [4:0] pop;
    // R8 reset state
    repeat (3) @(negedge clk);
    chk("R8 valid", {127'b0, res_valid}, 128'b0);
    chk("R8 illegal", {127'b0, res_illegal}, 128'b0);
    chk("R8 data", res_data, 128'b0);
    rst_n = 1'b1;

    // table walk
    for (int k = 0; k < NV; k++) begin
      @(negedge clk);
      drive(1'b1, TB_OP[k], ID_V, HI_V, TB_B[k]);
      @(negedge clk);
      drive(1'b0, 5'h03, '0, '0, '0);
      chk({TB_TAG[k], " R7 valid"}, {127'b0, res_valid}, 128'b1);
      chk({TB_TAG[k], " data"}, res_data, TB_E[k]);
    end

    // R7 back-to-back with varied data, model-checked
    pop = 5'h03; pe = '0;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      if (k > 0) begin
        chk("R7 b2b valid", {127'b0, res_valid}, 128'b1);
        chk("R7 b2b data", res_data, pe);
      end
      pa = {4{32'hA5C3_0000 + 32'(k * 32'h1111)}};
      pt = {4{32'h5A3C_F00F ^ 32'(k * 32'h0303_0101)}};
      for (int j = 0; j < 16; j++) pb[127-8*j -: 8] = 8'((j * 7 + k * 13) ^ (k << 5));
      pop = k[0] ? 5'h07 : 5'h03;
      pe = model(pop, pa, pt, pb);
      drive(1'b1, pop, pa, pt, pb);
    end
    @(negedge clk);
    drive(1'b0, 5'h03, '0, '0, '0);
    chk("R7 b2b last", res_data, pe);
    held = pe;

    // R10 idle: no valid, data held
    drive(1'b0, 5'h03, ID_V, HI_V, RHI_V);
    @(negedge clk);
    @(negedge clk);
    chk("R10 valid low", {127'b0, res_valid}, 128'b0);
    chk("R10 data held", res_data, held);

    // R9 illegal sub-opcodes
    for (int k = 0; k < 3; k++) begin
      logic [4:0] bop;
      bop = (k == 0) ? 5'h05 : (k == 1) ? 5'h00 : 5'h1F;
      drive(1'b1, bop, ID_V, HI_V, HI_V);
      @(negedge clk);
      drive(1'b0, 5'h03, '0, '0, '0);
      chk("R9 flag", {127'b0, res_illegal}, 128'b1);
      chk("R9 no valid", {127'b0, res_valid}, 128'b0);
      chk("R9 data held", res_data, held);
      @(negedge clk);
      chk("R9 flag drops", {127'b0, res_illegal}, 128'b0);
    end

    // R8 reset mid-run
    drive(1'b1, 5'h07, ID_V, HI_V, ID_V);
    @(negedge clk);
    drive(1'b0, 5'h03, '0, '0, '0);
    rst_n = 1'b0;
    #1;
    chk("R8 async valid", {127'b0, res_valid}, 128'b0);
    chk("R8 async data", res_data, 128'b0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule